// File: doc/BRIEF.md
# Stack Bytecode Execution Core

This block is a multicycle execution core for a small stack bytecode subset: push of a byte constant, add, subtract, bitwise AND, bitwise OR, duplicate, pop, swap and no-operation. It fetches opcode bytes one at a time from a byte-wide program memory and works on a word-wide operand stack held in an external data memory. The top stack word is also kept in a cached top-of-stack register, so that every opcode can run as a fixed register-transfer sequence. That sequence passes through a memory address register, a memory data register and a holding register.

The core starts at program address 0. The stack pointer starts one word below the stack base, which defaults to 1024, so the first push lands exactly at the base. The data memory read has one cycle of latency. An opcode that belongs to the wider bytecode family but is not in this subset raises a sticky flag and is otherwise treated as a no-operation. Any other byte halts the core with a fault indication.

Top module: `stack_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core returns to program address 0 with the stack pointer at STACK_BASE-1, and `fault`, `unimpl`, `dmem_rd` and `dmem_wr` all low.
- R2: Each instruction starts by reading the opcode at `imem_addr` and then advancing `imem_addr` by exactly one. The program address never moves in any other way.
- R3: BIPUSH (0x10) reads the following program byte, sign-extends it to DW bits, increments the stack pointer and writes the value there. The first push after reset lands at STACK_BASE.
- R4: IADD (0x60) and ISUB (0x64) pop the top word and replace the word below it with below+top or below-top respectively, written at the new stack pointer.
- R5: IAND (0x7E) and IOR (0xB0) pop the top word and replace the word below it with the bitwise AND or OR of the two words.
- R6: DUP (0x59) pushes a copy of the top-of-stack word at the incremented stack pointer.
- R7: POP (0x57) decrements the stack pointer and reloads the top of stack from memory without any memory write.
- R8: SWAP (0x5F) exchanges the top two stack words in memory and in the top-of-stack register, leaving the stack pointer unchanged.
- R9: Read data is used only in the cycle after the read strobe. The cycle after `dmem_rd` carries no strobe, and `dmem_rd` and `dmem_wr` are never high together.
- R10: The opcodes 0x13, 0x15, 0x36, 0x84, 0x99, 0x9B, 0x9F, 0xA7, 0xAC, 0xB6 and 0xC4 set `unimpl`, which then stays high until reset, and otherwise act as NOP (0x00).
- R11: Any other opcode byte raises `fault`, which stays high until reset. After that no memory strobe occurs and `imem_addr` stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | PC_W | Program byte address (program counter) |
| imem_rdata | input | 8 | Program byte at `imem_addr`, combinational read |
| dmem_addr | output | AW | Data memory word address |
| dmem_rd | output | 1 | Read strobe; data is returned on the next cycle |
| dmem_wr | output | 1 | Write strobe |
| dmem_wdata | output | DW | Write data |
| dmem_rdata | input | DW | Read data, valid the cycle after `dmem_rd` |
| fault | output | 1 | Core halted on an unknown opcode |
| unimpl | output | 1 | Sticky flag: an out-of-subset family opcode was skipped |

## Verification
The assertions watch the memory strobe protocol on every cycle: the idle cycle after a read and the exclusion of read and write. They also check that the program address only ever steps by one, that both flags stay set, and that the core stays silent with a frozen address once it has faulted. The arithmetic and stack results can only be shown by the bench scenarios. Each scenario runs a short program against a memory model that returns garbage on any cycle that is not a read response, then compares the final stack contents with values computed from the opcode meanings. Sign extension, the below-minus-top operand order, the reload of the cached top after a pop, and the swap are all checked this way.

// File: rtl/stack_core_pkg.sv
// Shared types for the stack bytecode core: sequencer states, opcode
// classes and ALU operations. Assumes byte-wide opcodes.
package stack_core_pkg;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_PUSH, ST_READ, ST_WAIT,
        ST_USE, ST_WRITE, ST_SWAP_HI, ST_SWAP_LO, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        CL_NOP, CL_BIPUSH, CL_DUP, CL_POP, CL_SWAP, CL_BIN, CL_UNIMPL, CL_ILLEGAL
    } op_class_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR
    } alu_op_e;

endpackage

// File: rtl/stack_decode.sv
// Opcode classifier: maps an opcode byte to its sequencing class and,
// for two-operand opcodes, the ALU operation. Purely combinational.
module stack_decode
    import stack_core_pkg::*;
(
    input  logic [7:0] opcode,
    output op_class_e  cls,
    output alu_op_e    alu_op
);
    // classify the byte
    always_comb begin
        cls    = CL_ILLEGAL;
        alu_op = ALU_ADD;
        unique case (opcode)
            8'h00: cls = CL_NOP;
            8'h10: cls = CL_BIPUSH;
            8'h59: cls = CL_DUP;
            8'h57: cls = CL_POP;
            8'h5F: cls = CL_SWAP;
            8'h60: begin cls = CL_BIN; alu_op = ALU_ADD; end
            8'h64: begin cls = CL_BIN; alu_op = ALU_SUB; end
            8'h7E: begin cls = CL_BIN; alu_op = ALU_AND; end
            8'hB0: begin cls = CL_BIN; alu_op = ALU_OR;  end
            8'h13, 8'h15, 8'h36, 8'h84, 8'h99, 8'h9B,
            8'h9F, 8'hA7, 8'hAC, 8'hB6, 8'hC4: cls = CL_UNIMPL;
            default: cls = CL_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/stack_alu.sv
// Two-operand ALU: combines the word popped from memory (lhs) with the
// saved top of stack (rhs). Subtraction is lhs minus rhs.
module stack_alu
    import stack_core_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  alu_op_e       op,
    output logic [DW-1:0] y
);
    // select the operation
    always_comb begin
        unique case (op)
            ALU_ADD: y = lhs + rhs;
            ALU_SUB: y = lhs - rhs;
            ALU_AND: y = lhs & rhs;
            default: y = lhs | rhs;
        endcase
    end
endmodule

// File: rtl/stack_core.sv
// Multicycle stack bytecode core. It fetches opcodes from a combinational
// byte program memory and keeps the operand stack in a word memory with
// one cycle of read latency. The top of stack is cached in a register.
// Every memory access goes through the address and data registers.
// Assumes the program memory returns the byte at imem_addr in the same cycle.
module stack_core
    import stack_core_pkg::*;
#(
    parameter int PC_W       = 12,
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int STACK_BASE = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] imem_addr,
    input  logic [7:0]      imem_rdata,
    output logic [AW-1:0]   dmem_addr,
    output logic            dmem_rd,
    output logic            dmem_wr,
    output logic [DW-1:0]   dmem_wdata,
    input  logic [DW-1:0]   dmem_rdata,
    output logic            fault,
    output logic            unimpl
);
    localparam logic [AW-1:0] LV_ADDR  = AW'(STACK_BASE);
    localparam logic [AW-1:0] SP_RESET = LV_ADDR - 1'b1;

    state_e          state;
    logic [PC_W-1:0] pc;
    logic [AW-1:0]   sp, mar;
    logic [DW-1:0]   mdr, tos, h;
    logic [7:0]      mbr;
    logic            unimpl_q;

    op_class_e       cls;
    alu_op_e         alu_op;
    logic [DW-1:0]   alu_y;
    logic [AW-1:0]   sp_inc, sp_dec;
    logic [DW-1:0]   mbr_sext;

    stack_decode u_dec (.opcode(mbr), .cls(cls), .alu_op(alu_op));

    stack_alu #(.DW(DW)) u_alu (.lhs(mdr), .rhs(h), .op(alu_op), .y(alu_y));

    // neighbouring stack addresses and the sign-extended immediate
    always_comb begin
        sp_inc   = sp + 1'b1;
        sp_dec   = sp - 1'b1;
        mbr_sext = {{(DW-8){mbr[7]}}, mbr};
    end

    // register-transfer sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_FETCH;
            pc       <= '0;
            sp       <= SP_RESET;
            mar      <= '0;
            mdr      <= '0;
            mbr      <= '0;
            tos      <= '0;
            h        <= '0;
            unimpl_q <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    mbr   <= imem_rdata;
                    pc    <= pc + 1'b1;
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    unique case (cls)
                        CL_NOP: state <= ST_FETCH;
                        CL_UNIMPL: begin
                            unimpl_q <= 1'b1;
                            state    <= ST_FETCH;
                        end
                        CL_BIPUSH: begin
                            mbr   <= imem_rdata;
                            pc    <= pc + 1'b1;
                            state <= ST_PUSH;
                        end
                        CL_DUP: begin
                            sp    <= sp_inc;
                            mar   <= sp_inc;
                            mdr   <= tos;
                            state <= ST_WRITE;
                        end
                        CL_POP, CL_BIN: begin
                            sp    <= sp_dec;
                            mar   <= sp_dec;
                            h     <= tos;
                            state <= ST_READ;
                        end
                        CL_SWAP: begin
                            mar   <= sp_dec;
                            state <= ST_READ;
                        end
                        default: state <= ST_HALT;
                    endcase
                end
                ST_PUSH: begin
                    sp    <= sp_inc;
                    mar   <= sp_inc;
                    mdr   <= mbr_sext;
                    tos   <= mbr_sext;
                    state <= ST_WRITE;
                end
                ST_READ: state <= ST_WAIT;
                ST_WAIT: begin
                    mdr   <= dmem_rdata;
                    state <= ST_USE;
                end
                ST_USE: begin
                    unique case (cls)
                        CL_BIN: begin
                            tos   <= alu_y;
                            mdr   <= alu_y;
                            state <= ST_WRITE;
                        end
                        CL_POP: begin
                            tos   <= mdr;
                            state <= ST_FETCH;
                        end
                        default: begin
                            h     <= mdr;
                            mar   <= sp;
                            state <= ST_SWAP_HI;
                        end
                    endcase
                end
                ST_WRITE: state <= ST_FETCH;
                ST_SWAP_HI: begin
                    mdr   <= tos;
                    mar   <= sp_dec;
                    state <= ST_SWAP_LO;
                end
                ST_SWAP_LO: begin
                    tos   <= h;
                    state <= ST_FETCH;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // port drive from the architectural registers and state
    always_comb begin
        imem_addr  = pc;
        dmem_addr  = mar;
        dmem_wdata = mdr;
        dmem_rd    = (state == ST_READ);
        dmem_wr    = (state == ST_WRITE) || (state == ST_SWAP_HI) || (state == ST_SWAP_LO);
        fault      = (state == ST_HALT);
        unimpl     = unimpl_q;
    end
endmodule

// File: rtl/stack_core_chk.sv
// Protocol checker for stack_core, bound to every instance. Observes the
// ports only; assumes a synchronous active-low reset.
module stack_core_chk #(
    parameter int PC_W = 12,
    parameter int AW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] imem_addr,
    input logic [AW-1:0]   dmem_addr,
    input logic            dmem_rd,
    input logic            dmem_wr,
    input logic            fault,
    input logic            unimpl
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == '0) && !fault && !unimpl && !dmem_rd && !dmem_wr);

    a_r2_pc_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(imem_addr) |-> imem_addr == PC_W'($past(imem_addr) + 1'b1));

    a_r9_idle_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |=> !dmem_rd && !dmem_wr);

    a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd && dmem_wr));

    a_r9_addr_held_for_read: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |=> $stable(dmem_addr));

    a_r10_unimpl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl |=> unimpl);

    a_r11_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault && !dmem_rd && !dmem_wr && $stable(imem_addr));
endmodule

bind stack_core stack_core_chk #(.PC_W(PC_W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .dmem_addr(dmem_addr),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .fault(fault), .unimpl(unimpl)
);

// File: tb/stack_core_tb.sv
// Directed bench for stack_core: one task per scenario, each loading a
// short program that ends in an unknown opcode and checking the stack.
module stack_core_tb;
    localparam int PC_W = 12, AW = 16, DW = 32, BASE = 1024;
    localparam logic [7:0] NOP = 8'h00, BIPUSH = 8'h10, DUP = 8'h59, POP = 8'h57,
        SWAP = 8'h5F, IADD = 8'h60, ISUB = 8'h64, IAND = 8'h7E, IOR = 8'hB0,
        STOP = 8'hFF, ILOAD = 8'h15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] imem_addr;
    logic [7:0]      imem_rdata;
    logic [AW-1:0]   dmem_addr;
    logic            dmem_rd, dmem_wr;
    logic [DW-1:0]   dmem_wdata;
    logic [DW-1:0]   dmem_rdata = '0;
    logic            fault, unimpl;

    logic [7:0]  prog [0:63];
    logic [31:0] mem  [0:2047];
    int          n_checks = 0, n_fail = 0, n_wr = 0, n_rd = 0;

    always #2 clk = ~clk;

    stack_core #(.PC_W(PC_W), .AW(AW), .DW(DW), .STACK_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .fault(fault), .unimpl(unimpl)
    );

    assign imem_rdata = (imem_addr < 64) ? prog[imem_addr[5:0]] : STOP;

    // data memory model: one-cycle read latency, garbage when no read is pending
    always @(posedge clk) begin
        if (dmem_wr) mem[dmem_addr[10:0]] <= dmem_wdata;
        dmem_rdata <= dmem_rd ? mem[dmem_addr[10:0]] : 32'hDEAD_BEEF;
        if (rst_n && dmem_wr) n_wr <= n_wr + 1;
        if (rst_n && dmem_rd) n_rd <= n_rd + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_clear();
        for (int i = 0; i < 64; i++) prog[i] = STOP;
        for (int i = 0; i < 2048; i++) mem[i] = 32'h5A5A_0000 + i;
    endtask

    // reset, run until the core faults on the terminating byte
    task automatic run_prog();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        n_wr = 0; n_rd = 0;
        rst_n = 1'b1;
        for (int i = 0; i < 500 && !fault; i++) @(negedge clk);
        check("R11 program reached fault", 32'(fault), 32'd1);
    endtask

    task automatic t_reset();
        load_clear();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 imem_addr", 32'(imem_addr), 32'd0);
        check("R1 fault", 32'(fault), 32'd0);
        check("R1 unimpl", 32'(unimpl), 32'd0);
        check("R1 strobes", {30'd0, dmem_rd, dmem_wr}, 32'd0);
    endtask

    task automatic t_push();
        load_clear();
        prog[0] = BIPUSH; prog[1] = 8'h05; prog[2] = BIPUSH; prog[3] = 8'hFD;
        run_prog();
        check("R3 first push at base", mem[BASE], 32'd5);
        check("R3 sign extension", mem[BASE+1], 32'hFFFF_FFFD);
        check("R2 pc after stop byte", 32'(imem_addr), 32'd5);
    endtask

    task automatic t_addsub();
        load_clear();
        prog[0] = BIPUSH; prog[1] = 8'd7; prog[2] = BIPUSH; prog[3] = 8'd9; prog[4] = IADD;
        run_prog();
        check("R4 IADD", mem[BASE], 32'd16);
        load_clear();
        prog[0] = BIPUSH; prog[1] = 8'd20; prog[2] = BIPUSH; prog[3] = 8'd6; prog[4] = ISUB;
        prog[5] = BIPUSH; prog[6] = 8'd1;
        run_prog();
        check("R4 ISUB below minus top", mem[BASE], 32'd14);
        check("R4 stack pointer after pop", mem[BASE+1], 32'd1);
    endtask

    task automatic t_logic();
        load_clear();
        prog[0] = BIPUSH; prog[1] = 8'h0C; prog[2] = BIPUSH; prog[3] = 8'h0A; prog[4] = IAND;
        prog[5] = DUP;
        run_prog();
        check("R5 IAND", mem[BASE+1], 32'h8);
        load_clear();
        prog[0] = BIPUSH; prog[1] = 8'h80; prog[2] = BIPUSH; prog[3] = 8'h03; prog[4] = IOR;
        run_prog();
        check("R5 IOR", mem[BASE], 32'hFFFF_FF83);
    endtask

    task automatic t_dup();
        load_clear();
        prog[0] = BIPUSH; prog[1] = 8'd42; prog[2] = DUP; prog[3] = IADD;
        run_prog();
        check("R6 DUP then add", mem[BASE], 32'd84);
        check("R6 DUP copy written", mem[BASE+1], 32'd42);
    endtask

    task automatic t_pop();
        load_clear();
        prog[0] = BIPUSH; prog[1] = 8'd1; prog[2] = BIPUSH; prog[3] = 8'd2; prog[4] = POP;
        prog[5] = DUP;
        run_prog();
        check("R7 POP reloads top", mem[BASE+1], 32'd1);
        check("R7 POP no write", 32'(n_wr), 32'd3);
        check("R9 reads", 32'(n_rd), 32'd1);
    endtask

    task automatic t_swap();
        load_clear();
        prog[0] = BIPUSH; prog[1] = 8'd3; prog[2] = BIPUSH; prog[3] = 8'd8; prog[4] = SWAP;
        prog[5] = DUP;
        run_prog();
        check("R8 SWAP lower", mem[BASE], 32'd8);
        check("R8 SWAP upper", mem[BASE+1], 32'd3);
        check("R8 SWAP cached top", mem[BASE+2], 32'd3);
    endtask

    task automatic t_unimpl();
        load_clear();
        prog[0] = BIPUSH; prog[1] = 8'd4; prog[2] = ILOAD; prog[3] = NOP;
        prog[4] = BIPUSH; prog[5] = 8'd6;
        run_prog();
        check("R10 unimpl set", 32'(unimpl), 32'd1);
        check("R10 acts as NOP", mem[BASE+1], 32'd6);
        check("R10 stack below kept", mem[BASE], 32'd4);
    endtask

    task automatic t_illegal();
        load_clear();
        prog[0] = STOP; prog[1] = BIPUSH; prog[2] = 8'd5;
        run_prog();
        repeat (10) @(negedge clk);
        check("R11 pc frozen", 32'(imem_addr), 32'd1);
        check("R11 no writes", 32'(n_wr), 32'd0);
        check("R11 no reads", 32'(n_rd), 32'd0);
        check("R11 memory untouched", mem[BASE], 32'h5A5A_0000 + BASE);
    endtask

    initial begin
        #(4 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_push();
        t_addsub();
        t_logic();
        t_dup();
        t_pop();
        t_swap();
        t_unimpl();
        t_reset();
        t_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule